// File: doc/BRIEF.md
# Segmented Gray-Coded Coarse Time Counter

This block is a free-running 48-bit coarse time counter for a time-stamping front end. It runs from the reference clock, 160 MHz in the target system, and takes about twenty days to wrap. Its main output is Gray coded, so only one output line switches on each step. This keeps supply noise and switching power low. A plain binary view of the same count is also given, for checking and for logic that wants arithmetic values.

Inside, the count is split into twelve 4-bit segments. A segment advances only when every segment below it sits at its terminal value of 15. That condition is held in a registered flag for each segment, computed one cycle ahead, so no carry has to travel across all twelve segments within one clock. This keeps the path short enough for clocks up to 200 MHz. A synchronous reset clears the count. A load port sets the count to any value, which lets a test reach segment boundaries and the full wrap without running for days.

Top module: `seg_gray_counter`

## Requirements
- R1: With `rst_i` high at a rising edge, both outputs are zero after that edge. Reset has priority over load and enable.
- R2: With `en_i` high and `load_i` low, `bin_o` grows by exactly one at each rising edge, modulo 2^48.
- R3: `gray_o` always equals `bin_o ^ (bin_o >> 1)`, the reflected binary Gray code: bit 47 equals binary bit 47, and each lower bit i is binary bit i XOR binary bit i+1.
- R4: Every increment changes exactly one bit of `gray_o`. This includes increments where segments wrap and a higher segment advances.
- R5: With `en_i`, `load_i` and `rst_i` all low, both outputs keep their value.
- R6: With `load_i` high and `rst_i` low, after the edge `bin_o` equals `load_val_i` and `gray_o` holds its Gray code. Load has priority over `en_i`.
- R7: From all ones (2^48-1), one increment gives zero on both outputs.
- R8: Segment k (bits 4k+3..4k) advances only on an increment where all bits below 4k are ones. This holds right after a load as well as in normal counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Preload strobe |
| load_val_i | input | 48 | Binary value taken on load |
| gray_o | output | 48 | Gray-coded count |
| bin_o | output | 48 | Binary view of the count |

## Verification
Two kinds of event can fall in the same cycle. The first is a load arriving while counting is enabled. The second is a reset arriving during a load. The bench drives `load_i` with `en_i` high, and drives `rst_i` together with `load_i`. The scoreboard expects the load value in the first case and zero in the second.

A second kind of overlap is a load that lands one step below a segment boundary. On the very next increment, the carry flag must already reflect the loaded value. Such loads are placed below every one of the eleven boundaries and below the full wrap. The bench then checks the binary value, the decoded Gray value and the single-bit change on each step.

// File: rtl/seg_gray_counter.sv
module seg_gray_counter #(
  parameter int SEG_W = 4,
  parameter int SEGS  = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  en_i,
  input  logic                  load_i,
  input  logic [SEG_W*SEGS-1:0] load_val_i,
  output logic [SEG_W*SEGS-1:0] gray_o,
  output logic [SEG_W*SEGS-1:0] bin_o
);
  localparam int W = SEG_W * SEGS;
  localparam logic [SEG_W-1:0] TOP  = '1;
  localparam logic [SEG_W-1:0] NEAR = {{(SEG_W-1){1'b1}}, 1'b0};
  localparam logic [SEG_W-1:0] ONE  = {{(SEG_W-1){1'b0}}, 1'b1};

  logic [SEG_W-1:0] seg_q [SEGS];
  logic [SEG_W-1:0] seg_d [SEGS];
  logic [SEGS-1:0]  cin;
  logic [SEGS-1:0]  lowrun;
  logic [W-1:0]     bin_w, bin_d, gray_q;

  assign cin[0]    = 1'b1;
  assign lowrun[0] = 1'b1;

  for (genvar k = 0; k < SEGS; k++) begin : g_seg
    assign bin_w[k*SEG_W +: SEG_W] = seg_q[k];
    assign bin_d[k*SEG_W +: SEG_W] = seg_d[k];

    always_comb begin
      if (rst_i)                seg_d[k] = '0;
      else if (load_i)          seg_d[k] = load_val_i[k*SEG_W +: SEG_W];
      else if (en_i && cin[k])  seg_d[k] = seg_q[k] + ONE;
      else                      seg_d[k] = seg_q[k];
    end

    always_ff @(posedge clk_i) seg_q[k] <= seg_d[k];

    if (k > 0) begin : g_carry
      logic carry_q;
      if (k == 1) begin : g_first
        assign lowrun[k] = (seg_q[0] == NEAR);
      end else begin : g_rest
        assign lowrun[k] = lowrun[k-1] && (seg_q[k-1] == TOP);
      end

      always_ff @(posedge clk_i) begin
        if (rst_i)       carry_q <= 1'b0;
        else if (load_i) carry_q <= &load_val_i[k*SEG_W-1:0];
        else if (en_i)   carry_q <= lowrun[k];
      end
      assign cin[k] = carry_q;

      // R8
      carry_track_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        carry_q == (&bin_w[k*SEG_W-1:0]));
    end
  end

  always_ff @(posedge clk_i) gray_q <= bin_d ^ (bin_d >> 1);

  assign gray_o = gray_q;
  assign bin_o  = bin_w;

  logic [W-1:0] prev_gray_q;
  logic inc_q, hold_q, rst_q;
  always_ff @(posedge clk_i) begin
    prev_gray_q <= gray_q;
    inc_q       <= !rst_i && !load_i && en_i;
    hold_q      <= !rst_i && !load_i && !en_i;
    rst_q       <= rst_i;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    rst_q |-> (gray_q == '0 && bin_w == '0));

  // R3
  gray_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_q |-> gray_q == (bin_w ^ (bin_w >> 1)));

  // R4
  gray_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    inc_q |-> $countones(gray_q ^ prev_gray_q) == 1);

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_q |-> gray_q == prev_gray_q);
endmodule

// File: tb/test_seg_gray_counter.sv
module test_seg_gray_counter;
  localparam int W = 48;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, load = 1'b0;
  logic [W-1:0] lval = '0;
  logic [W-1:0] gray, bin;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [W-1:0] b; bit inc; string req; } item_t;
  item_t q[$];
  logic [W-1:0] ref_bin = '0;

  seg_gray_counter i_seg_gray_counter (
    .clk_i(clk), .rst_i(rst), .en_i(en), .load_i(load),
    .load_val_i(lval), .gray_o(gray), .bin_o(bin));

  always #4 clk = ~clk;

  function automatic logic [W-1:0] g2b(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  task automatic step(input bit r, input bit e, input bit l,
                      input logic [W-1:0] v, input string req);
    item_t it;
    @(negedge clk);
    rst = r; en = e; load = l; lval = v;
    if (r)      ref_bin = '0;
    else if (l) ref_bin = v;
    else if (e) ref_bin = ref_bin + 1'b1;
    it.b = ref_bin; it.inc = !r && !l && e; it.req = req;
    q.push_back(it);
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [W-1:0] prev_gray = '0;
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(bin == it.b, it.req, bin, it.b);
      check(g2b(gray) == it.b, {it.req, "/R3"}, g2b(gray), it.b);
      if (it.inc)
        check($countones(gray ^ prev_gray) == 1, {it.req, "/R4"},
              gray ^ prev_gray, '0);
    end
    prev_gray = gray;
  end

  initial begin
    for (int i = 0; i < 3; i++) step(1, 1, 0, '0, "R1");
    for (int i = 0; i < 40; i++) step(0, 1, 0, '0, "R2");
    for (int i = 0; i < 5; i++) step(0, 0, 0, '0, "R5");
    for (int k = 1; k < 12; k++) begin
      step(0, 0, 1, (48'd1 << (4*k)) - 48'd3, "R6");
      for (int i = 0; i < 5; i++) step(0, 1, 0, '0, "R8");
    end
    step(0, 0, 1, '1 - 48'd2, "R6");
    for (int i = 0; i < 5; i++) step(0, 1, 0, '0, "R7");
    step(0, 1, 1, 48'h0123_4567_89AB, "R6");
    step(0, 1, 0, '0, "R2");
    step(1, 1, 1, 48'hFFFF_0000_FFFF, "R1");
    step(0, 0, 0, '0, "R5");
    step(0, 1, 0, '0, "R2");
    step(0, 0, 0, '0, "R5");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule